// File: doc/BRIEF.md
# Temporal Census Feature Encoder

This block turns the brightness history of one pixel position into a compact binary signature. Each input word carries `NUM_SAMPLES` grayscale samples of the same pixel, one for each of a run of consecutive frames. Sample 0 is the earliest. The encoder derives one bit from each of three families of greater-than tests, all taken along the time axis:

- sample against sample;
- sample against the temporal mean;
- one pair-sum against another pair-sum.

The bits are packed into a fixed 64-bit word. The result is a signature that a matcher can compare with a Hamming distance instead of a correlation.

The block has a two-stage pipeline. It accepts one pixel on every clock cycle and returns its feature with a fixed latency. There is no back-pressure. A valid strobe travels with the data. When the tests outnumber the feature bits, the surplus tests are dropped. When there are fewer tests than bits, the unused high bits are zero.

Top module: `tcen_encoder`

## Requirements
- R1: Pairwise tests fill bits 0 upward. Pairs (i, j) with i < j are enumerated (0,1), (0,2), … (0,N-1), (1,2), … (N-2,N-1). The bit for pair (i, j) is 1 exactly when sample i is greater than sample j.
- R2: The next N bits, at position P + i with P = N(N-1)/2, hold the mean test for sample i. The bit is 1 exactly when N times sample i exceeds the sum of all N samples. No division is used.
- R3: The pair-sum tests follow the mean bits. Each pair of samples forms an 11-bit sum, and the pairs are ordered as in R1. Pairs of pair-sums (p, q) with p < q are taken in the same enumeration. The bit is 1 exactly when sum p is greater than sum q.
- R4: Only the first 64 tests in the order of R1 to R3 are kept. With N = 10 the feature holds the 45 pairwise bits, then the 10 mean bits, then the first 9 pair-sum tests.
- R5: When fewer than 64 tests exist, all bits above the last test are 0. With N = 5, bits 60 to 63 are 0.
- R6: A test between equal values always yields 0. A pixel whose samples are all equal therefore encodes as an all-zero feature.
- R7: `out_valid` repeats `in_valid` exactly two clock edges later. A new pixel may be presented on every cycle, and each feature appears two edges after its pixel.
- R8: The synchronous active-low reset empties the pipeline. After a reset edge, `out_valid` is 0 and `out_feat` is 0, and no pixel that was in flight is delivered.
- R9: Full-scale samples (1023) give correct results with no overflow in either the mean products or the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pixel samples present this cycle |
| in_pix | input | NUM_SAMPLES*PIX_W | Samples; sample t at bits [t*PIX_W +: PIX_W], sample 0 earliest |
| out_valid | output | 1 | Feature present this cycle |
| out_feat | output | FEAT_W | Encoded temporal feature |

## Verification
The tie rule and the mean test meet in the same cycle whenever a sample is exactly equal to the temporal mean. In that case N times the sample equals the total, and the bit must be 0. Pixels are built so that this coincides with equal pair-sums and with equal samples: a staircase whose mean is itself one of the samples, flat pixels, and full-scale pixels. These are sent back to back with random pixels and with bubbles, and a reset is applied while a pixel is in flight. A reference model written from R1 to R5 predicts every feature. Separate instances with N = 10 and N = 5 cover the truncation case and the zero-fill case.

// File: rtl/tcen_pkg.sv
// Package: shared sizing and the compile-time comparison schedule.
// Assumes N >= 2. Every function is evaluated at elaboration only.
package tcen_pkg;

    typedef enum logic [1:0] {
        CMP_PAIR = 2'd0,
        CMP_MEAN = 2'd1,
        CMP_SUM  = 2'd2,
        CMP_NONE = 2'd3
    } cmp_kind_e;

    // Number of unordered pairs drawn from n items.
    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // First member of pair number p, pairs in lexicographic order (i<j).
    function automatic int pair_first(input int p, input int n);
        int idx = 0;
        int r = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (idx == p) r = i;
                idx++;
            end
        end
        return r;
    endfunction

    // Second member of pair number p, same order as pair_first.
    function automatic int pair_second(input int p, input int n);
        int idx = 0;
        int r = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (idx == p) r = j;
                idx++;
            end
        end
        return r;
    endfunction

    // Total number of tests before truncation.
    function automatic int test_count(input int n);
        return pair_count(n) + n + pair_count(pair_count(n));
    endfunction

    // Number of feature bits carrying a test.
    function automatic int used_bits(input int n, input int feat_w);
        return (test_count(n) < feat_w) ? test_count(n) : feat_w;
    endfunction

    // Family of the test that lands on feature bit k.
    function automatic cmp_kind_e cmp_kind(input int k, input int n);
        int np = pair_count(n);
        if (k < np)                     return CMP_PAIR;
        else if (k < np + n)            return CMP_MEAN;
        else if (k < test_count(n))     return CMP_SUM;
        else                            return CMP_NONE;
    endfunction

    // Sample index operand sel (0..3) of the test on feature bit k.
    function automatic int cmp_op(input int k, input int n, input int sel);
        int np = pair_count(n);
        int m;
        int p;
        int q;
        int r = 0;
        if (k < np) begin
            if (sel == 0) r = pair_first(k, n);
            if (sel == 1) r = pair_second(k, n);
        end else if (k < np + n) begin
            if (sel == 0) r = k - np;
        end else if (k < test_count(n)) begin
            m = k - np - n;
            p = pair_first(m, np);
            q = pair_second(m, np);
            if (sel == 0) r = pair_first(p, n);
            if (sel == 1) r = pair_second(p, n);
            if (sel == 2) r = pair_first(q, n);
            if (sel == 3) r = pair_second(q, n);
        end
        return r;
    endfunction

endpackage

// File: rtl/tcen_sum.sv
// Stage 1: registers the samples together with their total.
// Assumes SUM_W is large enough to hold NUM * (2**PIX_W - 1) and any sample times NUM.
module tcen_sum #(
    parameter int NUM   = 10,
    parameter int PIX_W = 10,
    parameter int SUM_W = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [NUM*PIX_W-1:0]   pix_i,
    output logic                   valid_o,
    output logic [NUM*PIX_W-1:0]   pix_o,
    output logic [SUM_W-1:0]       total_o
);

    logic [SUM_W-1:0] acc;

    // Adds every sample of the incoming pixel.
    always_comb begin
        acc = '0;
        for (int t = 0; t < NUM; t++) begin
            acc = acc + SUM_W'(pix_i[t*PIX_W +: PIX_W]);
        end
    end

    // Pipeline register for stage 1, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            pix_o   <= '0;
            total_o <= '0;
        end else begin
            valid_o <= valid_i;
            pix_o   <= pix_i;
            total_o <= acc;
        end
    end

endmodule

// File: rtl/tcen_feature.sv
// Stage 2: computes one greater-than test per feature bit and registers the feature.
// Operands come from the compile-time schedule in tcen_pkg. Bits with no test
// compare zero against zero, so they always read 0.
module tcen_feature
    import tcen_pkg::*;
#(
    parameter int NUM    = 10,
    parameter int PIX_W  = 10,
    parameter int SUM_W  = 15,
    parameter int FEAT_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [NUM*PIX_W-1:0]   pix_i,
    input  logic [SUM_W-1:0]       total_i,
    output logic                   valid_o,
    output logic [FEAT_W-1:0]      feat_o
);

    logic [FEAT_W-1:0] bits;

    for (genvar k = 0; k < FEAT_W; k++) begin : g_bit
        localparam cmp_kind_e KIND = cmp_kind(k, NUM);
        localparam int IA = cmp_op(k, NUM, 0);
        localparam int IB = cmp_op(k, NUM, 1);
        localparam int IC = cmp_op(k, NUM, 2);
        localparam int ID = cmp_op(k, NUM, 3);

        logic [SUM_W-1:0] lhs;
        logic [SUM_W-1:0] rhs;

        if (KIND == CMP_PAIR) begin : g_pair
            assign lhs = SUM_W'(pix_i[IA*PIX_W +: PIX_W]);
            assign rhs = SUM_W'(pix_i[IB*PIX_W +: PIX_W]);
        end else if (KIND == CMP_MEAN) begin : g_mean
            assign lhs = SUM_W'(pix_i[IA*PIX_W +: PIX_W]) * SUM_W'(NUM);
            assign rhs = total_i;
        end else if (KIND == CMP_SUM) begin : g_psum
            assign lhs = SUM_W'(pix_i[IA*PIX_W +: PIX_W]) + SUM_W'(pix_i[IB*PIX_W +: PIX_W]);
            assign rhs = SUM_W'(pix_i[IC*PIX_W +: PIX_W]) + SUM_W'(pix_i[ID*PIX_W +: PIX_W]);
        end else begin : g_none
            assign lhs = '0;
            assign rhs = '0;
        end

        // Strict comparison: equal operands give 0.
        assign bits[k] = (lhs > rhs);
    end

    // Pipeline register for stage 2, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            feat_o  <= '0;
        end else begin
            valid_o <= valid_i;
            feat_o  <= bits;
        end
    end

endmodule

// File: rtl/tcen_encoder.sv
// Top: temporal census encoder, two pipeline stages with one pixel per cycle.
// Assumes NUM_SAMPLES >= 2 and that in_pix holds sample 0 (the earliest) in its lowest bits.
module tcen_encoder
    import tcen_pkg::*;
#(
    parameter int NUM_SAMPLES = 10,
    parameter int PIX_W       = 10,
    parameter int FEAT_W      = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [NUM_SAMPLES*PIX_W-1:0]   in_pix,
    output logic                           out_valid,
    output logic [FEAT_W-1:0]              out_feat
);

    localparam int SUM_W   = PIX_W + $clog2(NUM_SAMPLES) + 1;
    localparam int NPAIR   = pair_count(NUM_SAMPLES);
    localparam int USED    = used_bits(NUM_SAMPLES, FEAT_W);
    localparam int MEAN_LO = NPAIR;
    localparam int MEAN_HI = NPAIR + NUM_SAMPLES - 1;

    logic                          s1_valid;
    logic [NUM_SAMPLES*PIX_W-1:0]  s1_pix;
    logic [SUM_W-1:0]              s1_total;

    tcen_sum #(
        .NUM   (NUM_SAMPLES),
        .PIX_W (PIX_W),
        .SUM_W (SUM_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .pix_i   (in_pix),
        .valid_o (s1_valid),
        .pix_o   (s1_pix),
        .total_o (s1_total)
    );

    tcen_feature #(
        .NUM    (NUM_SAMPLES),
        .PIX_W  (PIX_W),
        .SUM_W  (SUM_W),
        .FEAT_W (FEAT_W)
    ) u_feat (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s1_valid),
        .pix_i   (s1_pix),
        .total_i (s1_total),
        .valid_o (out_valid),
        .feat_o  (out_feat)
    );

    // ---------------- assertions ----------------
    logic [1:0] age;
    logic       s1_flat;

    // Counts edges since reset, saturating at 2, so the latency check starts only once the pipeline is filled from live inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // Flags a stage-1 pixel whose samples are all equal.
    always_comb begin
        s1_flat = 1'b1;
        for (int t = 1; t < NUM_SAMPLES; t++) begin
            if (s1_pix[t*PIX_W +: PIX_W] != s1_pix[0 +: PIX_W]) s1_flat = 1'b0;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));               // R7

    AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_flat) |=> (out_feat == '0));                         // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_feat == '0));                          // R8

    if (USED < FEAT_W) begin : g_fill_chk
        AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_feat[FEAT_W-1:USED] == '0));                  // R5
    end

    if (MEAN_HI < FEAT_W) begin : g_mean_chk
        AST_MEAN_NOT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_feat[MEAN_HI:MEAN_LO] != '1));                // R2
    end

endmodule

// File: tb/tcen_encoder_test.sv
// Scoreboard bench: a driver task queues expected features and a negedge monitor compares them.
module tcen_encoder_test;

    localparam int PW = 10;

    typedef struct {
        logic [63:0] f;
        int          stamp;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [99:0]   in_pix = '0;
    logic          out_valid10, out_valid5;
    logic [63:0]   out_feat10, out_feat5;

    exp_t q10[$];
    exp_t q5[$];
    int   edges = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    tcen_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid10), .out_feat(out_feat10)
    );

    tcen_encoder #(.NUM_SAMPLES(5)) uut_short (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix[49:0]),
        .out_valid(out_valid5), .out_feat(out_feat5)
    );

    // Reference model written from R1..R5.
    function automatic logic [63:0] ref_feat(input int n, input int s[10]);
        logic [63:0] r = '0;
        int k = 0;
        int tot = 0;
        int ps[45];
        int np = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++) begin
                if (k < 64) r[k] = (s[i] > s[j]);
                k++;
            end
        for (int i = 0; i < n; i++) tot += s[i];
        for (int i = 0; i < n; i++) begin
            if (k < 64) r[k] = (s[i] * n > tot);
            k++;
        end
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++) begin
                ps[np] = s[i] + s[j];
                np++;
            end
        for (int p = 0; p < np; p++)
            for (int q = p + 1; q < np; q++) begin
                if (k < 64) r[k] = (ps[p] > ps[q]);
                k++;
            end
        return r;
    endfunction

    function automatic string region(input int n, input logic [63:0] diff);
        int np = n * (n - 1) / 2;
        for (int b = 0; b < 64; b++) begin
            if (diff[b]) begin
                if (b < np)               return "R1";
                if (b < np + n)           return "R2";
                if (b < np + n + np*(np-1)/2) return (b == 63) ? "R4" : "R3";
                return "R5";
            end
        end
        return "R1";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: presents one cycle of input and queues the expected results.
    task automatic drive(input int s[10], input bit v);
        exp_t e;
        for (int t = 0; t < 10; t++) in_pix[t*PW +: PW] = PW'(s[t]);
        in_valid = v;
        if (v) begin
            e.stamp = edges + 2;
            e.f = ref_feat(10, s);
            q10.push_back(e);
            e.f = ref_feat(5, s);
            q5.push_back(e);
        end
        @(negedge clk);
    endtask

    // Monitor: compares every delivered feature with the queue head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (out_valid10) begin
                if (q10.size() == 0) check(1'b0, "R7", "unexpected N=10 output", out_feat10, 64'h0);
                else begin
                    e = q10.pop_front();
                    check(edges == e.stamp, "R7", "N=10 latency", 64'(edges), 64'(e.stamp));
                    check(out_feat10 == e.f, region(10, out_feat10 ^ e.f), "N=10 feature", out_feat10, e.f);
                end
            end
            if (out_valid5) begin
                if (q5.size() == 0) check(1'b0, "R7", "unexpected N=5 output", out_feat5, 64'h0);
                else begin
                    e = q5.pop_front();
                    check(edges == e.stamp, "R7", "N=5 latency", 64'(edges), 64'(e.stamp));
                    check(out_feat5 == e.f, region(5, out_feat5 ^ e.f), "N=5 feature", out_feat5, e.f);
                end
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 64'h0, 64'h0);
        finish_run();
    end

    initial begin
        int s[10];
        repeat (3) @(negedge clk);
        // R8: reset state.
        check(!out_valid10 && !out_valid5, "R8", "valid during reset", {62'h0, out_valid10, out_valid5}, 64'h0);
        check(out_feat10 == 0 && out_feat5 == 0, "R8", "feature during reset", out_feat10 | out_feat5, 64'h0);
        rst_n = 1'b1;

        // R6: flat pixels; R9: full scale.
        for (int t = 0; t < 10; t++) s[t] = 0;
        drive(s, 1);
        for (int t = 0; t < 10; t++) s[t] = 1023;
        drive(s, 1);
        // R9: one full-scale sample, the rest zero.
        for (int t = 0; t < 10; t++) s[t] = (t == 3) ? 1023 : 0;
        drive(s, 1);
        // R1: rising and falling staircases.
        for (int t = 0; t < 10; t++) s[t] = t * 100;
        drive(s, 1);
        for (int t = 0; t < 10; t++) s[t] = 1000 - t * 100;
        drive(s, 1);
        // R2/R6: samples equal to the mean exactly, with equal pair sums.
        for (int t = 0; t < 10; t++) s[t] = (t == 9) ? 500 : (t + 1) * 100;
        drive(s, 1);
        for (int t = 0; t < 10; t++) s[t] = (t % 2) ? 600 : 400;
        drive(s, 1);
        // R3/R4: random pixels back to back.
        for (int v = 0; v < 60; v++) begin
            for (int t = 0; t < 10; t++) s[t] = $urandom_range(0, 1023);
            drive(s, 1);
        end
        // R7: random pixels with bubbles.
        for (int v = 0; v < 40; v++) begin
            for (int t = 0; t < 10; t++) s[t] = $urandom_range(0, 1023);
            drive(s, (v % 3) != 1);
        end
        drive(s, 0);
        drive(s, 0);
        drive(s, 0);

        // R8: reset with a pixel in flight; it must never appear.
        for (int t = 0; t < 10; t++) s[t] = 77 * t;
        drive(s, 1);
        in_valid = 1'b0;
        rst_n = 1'b0;
        q10.delete();
        q5.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(!out_valid10 && !out_valid5, "R8", "valid after reset", {62'h0, out_valid10, out_valid5}, 64'h0);
        check(out_feat10 == 0 && out_feat5 == 0, "R8", "feature after reset", out_feat10 | out_feat5, 64'h0);
        @(negedge clk);
        check(!out_valid10 && !out_valid5, "R8", "in-flight pixel dropped", {62'h0, out_valid10, out_valid5}, 64'h0);

        // Traffic after reset.
        for (int v = 0; v < 10; v++) begin
            for (int t = 0; t < 10; t++) s[t] = $urandom_range(0, 1023);
            drive(s, 1);
        end
        drive(s, 0);
        drive(s, 0);
        drive(s, 0);
        check(q10.size() == 0 && q5.size() == 0, "R7", "features left undelivered",
              64'(q10.size() + q5.size()), 64'h0);
        finish_run();
    end

endmodule